// File: doc/BRIEF.md
# Multi-Bank GPIO Interrupt Aggregator

This block sits between a set of 32-pin GPIO banks and an interrupt controller. It decodes a small register window. One word in that window is a per-group interrupt enable register. The rest is made up of up to five equal-sized bank register groups, and each access to one of them is passed on to the owning bank as a one-hot select plus a word index. Read data comes back from the selected bank, or from the enable register, or is zero.

Each bank delivers a 32-bit pending-status word, which the aggregator splits into two 16-pin groups. Every group drives its own level-sensitive request line. A line stays high while any pin of its group is pending and the group's enable bit is set, and it falls once software has cleared the pending bits in the bank.

A build-time option selects direct mode. In direct mode the first few pins of bank 0 each get a private request line, all grouped lines are silent, and only the lowest enable bit is kept.

Top module: `gpio_irq_aggr`

## Requirements
- R1: The bank groups start at byte offsets 0x10 + 0x28*k for k = 0..NUM_BANKS-1. Each group is 0x28 bytes (ten words) long. An access inside group k raises only bit k of `bank_sel` and drives `bank_word` with (offset - base_k)/4, in the range 0..9.
- R2: An access to any offset that is neither the enable word (0x08..0x0B) nor inside a bank group raises no `bank_sel` bit and reads zero. A write there leaves the enable register unchanged, and so does a write that lands in a bank group.
- R3: A read inside bank group k returns `bank_rdata[32*k+31:32*k]`.
- R4: The enable register sits at offset 0x08. Bit g enables request group g. A write stores `reg_wdata[2*NUM_BANKS-1:0]`, a read returns those bits with all higher bits at zero, and reset clears the register.
- R5: In grouped mode, request line 2k covers status bits 15:0 of bank k and line 2k+1 covers bits 31:16 of bank k. A line is high when its enable bit is set and at least one of its 16 status bits is set.
- R6: A request line is a level. It stays high for as long as its enabled status bits remain set, and it drops once they are all clear.
- R7: Every request output is registered. It reflects the status and enable values present at the previous rising clock edge, so a change to either shows up one cycle later.
- R8: When DIRECT_PINS > 0, `irq_direct[i]` follows enable bit 0 ANDed with status bit i of bank 0, for i < DIRECT_PINS. All grouped lines stay low. Enable bits above bit 0 are dropped on write and read as zero.
- R9: Synchronous active-high reset drives every request output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_sel | input | 1 | Register access valid this cycle |
| reg_we | input | 1 | Access is a write |
| reg_addr | input | ADDR_W | Byte offset inside the window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational, zero when idle |
| bank_sel | output | NUM_BANKS | One-hot select of the addressed bank group |
| bank_word | output | 4 | Word index inside the selected bank group |
| bank_rdata | input | 32*NUM_BANKS | Read data from each bank, bank k in bits 32k+31:32k |
| bank_status | input | 32*NUM_BANKS | Pending-status words from the banks |
| irq_grp | output | 2*NUM_BANKS | Grouped level request lines |
| irq_direct | output | max(DIRECT_PINS,1) | Per-pin request lines in direct mode |

## Verification
The decode outputs and the read data are combinational, so the bench samples them 1 ns after it drives an access. The enable register takes a write at the edge that ends the access. Each request line needs one more edge after its inputs change. That means a new status value shows up at the first falling edge after it was driven, and a new enable value shows up one full cycle after the write's own edge. The bench checks the old value at the intermediate falling edge on purpose. A behavioural model sits on the rising edge and takes the inputs that DUT registers take. It is compared with both a grouped-mode instance and a direct-mode instance at every falling edge, while directed and random status patterns are applied.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int WORD_W          = 32;
    localparam int GROUP_PINS      = 16;
    localparam int GROUPS_PER_BANK = WORD_W / GROUP_PINS;
    localparam int MAX_BANKS       = 5;
    localparam int MAX_DIRECT      = GROUP_PINS;

    localparam int ENABLE_OFS      = 'h08;
    localparam int BANK0_OFS       = 'h10;
    localparam int BANK_STRIDE     = 'h28;
    localparam int BANK_WORDS      = BANK_STRIDE / 4;
    localparam int WORD_SEL_W      = $clog2(BANK_WORDS);
    localparam int BANK_IDX_W      = $clog2(MAX_BANKS);

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_ENABLE,
        ACC_BANK
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e               kind;
        logic [BANK_IDX_W-1:0]   bank;
        logic [WORD_SEL_W-1:0]   word;
    } acc_dec_t;

    function automatic int bank_base(input int k);
        return BANK0_OFS + k * BANK_STRIDE;
    endfunction

endpackage

// File: rtl/gpio_irq_regdec.sv
module gpio_irq_regdec
    import gpio_irq_pkg::*;
#(
    parameter int              NB      = 5,
    parameter int              ADDR_W  = 8,
    parameter int              EN_W    = 10,
    parameter logic [EN_W-1:0] EN_MASK = {EN_W{1'b1}}
)(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_sel,
    input  logic                  reg_we,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [WORD_W-1:0]     reg_wdata,
    input  logic [NB*WORD_W-1:0]  bank_rdata,
    output logic [WORD_W-1:0]     reg_rdata,
    output logic [NB-1:0]         bank_sel,
    output logic [WORD_SEL_W-1:0] bank_word,
    output logic [EN_W-1:0]       en_q
);

    localparam logic [ADDR_W-3:0] ENA_WADDR = (ADDR_W-2)'(ENABLE_OFS / 4);

    acc_dec_t dec;

    // Address decode: enable word first, bank groups by range compare
    always_comb begin
        dec = '{kind: ACC_NONE, bank: '0, word: '0};
        if (reg_addr[ADDR_W-1:2] == ENA_WADDR) begin
            dec.kind = ACC_ENABLE;
        end
        for (int k = 0; k < NB; k++) begin
            if (reg_addr >= ADDR_W'(bank_base(k)) &&
                reg_addr <  ADDR_W'(bank_base(k) + BANK_STRIDE)) begin
                dec.kind = ACC_BANK;
                dec.bank = BANK_IDX_W'(k);
                dec.word = WORD_SEL_W'((reg_addr - ADDR_W'(bank_base(k))) >> 2);
            end
        end
    end

    always_comb begin
        for (int k = 0; k < NB; k++) begin
            bank_sel[k] = reg_sel && (dec.kind == ACC_BANK) &&
                          (dec.bank == BANK_IDX_W'(k));
        end
    end

    assign bank_word = dec.word;

    always_comb begin
        reg_rdata = '0;
        if (reg_sel) begin
            case (dec.kind)
                ACC_ENABLE: reg_rdata = WORD_W'(en_q);
                ACC_BANK:   reg_rdata = bank_rdata[WORD_W*dec.bank +: WORD_W];
                default:    reg_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (reg_sel && reg_we && dec.kind == ACC_ENABLE) begin
            en_q <= reg_wdata[EN_W-1:0] & EN_MASK;
        end
    end

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^reg_wdata[WORD_W-1:EN_W];

    // R1
    bank_sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_sel));

    // R2
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_sel && bank_sel == '0 && reg_addr[ADDR_W-1:2] != ENA_WADDR)
        |-> reg_rdata == '0);

    // R4
    en_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_sel && reg_we && reg_addr[ADDR_W-1:2] == ENA_WADDR)
        |=> $stable(en_q));

endmodule

// File: rtl/gpio_irq_reduce.sv
module gpio_irq_reduce
    import gpio_irq_pkg::*;
#(
    parameter int NB          = 5,
    parameter int DIRECT_PINS = 0,
    parameter int EN_W        = 10,
    parameter int DW          = 1
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NB*WORD_W-1:0] status,
    input  logic [EN_W-1:0]      en_q,
    output logic [EN_W-1:0]      irq_grp,
    output logic [DW-1:0]        irq_direct
);

    localparam int NG = NB * GROUPS_PER_BANK;

    logic [NG-1:0] grp_d;
    logic [DW-1:0] dir_d;

    generate
        if (DIRECT_PINS == 0) begin : g_grouped
            for (genvar g = 0; g < NG; g++) begin : g_line
                assign grp_d[g] = en_q[g] && (|status[GROUP_PINS*g +: GROUP_PINS]);

                // R5
                grp_raise_chk: assert property (@(posedge clk) disable iff (rst)
                    (en_q[g] && status[GROUP_PINS*g +: GROUP_PINS] != '0)
                    |=> irq_grp[g]);

                // R6
                grp_drop_chk: assert property (@(posedge clk) disable iff (rst)
                    (status[GROUP_PINS*g +: GROUP_PINS] == '0) |=> !irq_grp[g]);
            end
            assign dir_d = '0;
        end else begin : g_direct
            assign grp_d = '0;
            assign dir_d = {DW{en_q[0]}} & status[DW-1:0];

            for (genvar p = 0; p < DW; p++) begin : g_pin
                // R8
                dir_follow_chk: assert property (@(posedge clk) disable iff (rst)
                    (en_q[0] && status[p]) |=> irq_direct[p]);
            end

            // R8
            dir_gate_chk: assert property (@(posedge clk) disable iff (rst)
                !en_q[0] |=> irq_direct == '0);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_grp    <= '0;
            irq_direct <= '0;
        end else begin
            irq_grp    <= grp_d;
            irq_direct <= dir_d;
        end
    end

endmodule

// File: rtl/gpio_irq_aggr.sv
module gpio_irq_aggr
    import gpio_irq_pkg::*;
#(
    parameter int NUM_BANKS   = 5,
    parameter int ADDR_W      = 8,
    parameter int DIRECT_PINS = 0,
    localparam int EN_W       = NUM_BANKS * GROUPS_PER_BANK,
    localparam int DW         = (DIRECT_PINS > 0) ? DIRECT_PINS : 1
)(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        reg_sel,
    input  logic                        reg_we,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [WORD_W-1:0]           reg_wdata,
    output logic [WORD_W-1:0]           reg_rdata,
    output logic [NUM_BANKS-1:0]        bank_sel,
    output logic [WORD_SEL_W-1:0]       bank_word,
    input  logic [NUM_BANKS*WORD_W-1:0] bank_rdata,
    input  logic [NUM_BANKS*WORD_W-1:0] bank_status,
    output logic [EN_W-1:0]             irq_grp,
    output logic [DW-1:0]               irq_direct
);

    localparam logic [EN_W-1:0] EN_MASK =
        (DIRECT_PINS > 0) ? EN_W'(1) : {EN_W{1'b1}};

    generate
        if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS ||
            DIRECT_PINS < 0 || DIRECT_PINS > MAX_DIRECT) begin : g_bad_cfg
            $error("gpio_irq_aggr: unsupported parameter set");
        end
    endgenerate

    logic [EN_W-1:0] en_q;

    gpio_irq_regdec #(
        .NB      (NUM_BANKS),
        .ADDR_W  (ADDR_W),
        .EN_W    (EN_W),
        .EN_MASK (EN_MASK)
    ) u_regdec (
        .clk        (clk),
        .rst        (rst),
        .reg_sel    (reg_sel),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .bank_rdata (bank_rdata),
        .reg_rdata  (reg_rdata),
        .bank_sel   (bank_sel),
        .bank_word  (bank_word),
        .en_q       (en_q)
    );

    gpio_irq_reduce #(
        .NB          (NUM_BANKS),
        .DIRECT_PINS (DIRECT_PINS),
        .EN_W        (EN_W),
        .DW          (DW)
    ) u_reduce (
        .clk        (clk),
        .rst        (rst),
        .status     (bank_status),
        .en_q       (en_q),
        .irq_grp    (irq_grp),
        .irq_direct (irq_direct)
    );

endmodule

// File: tb/gpio_irq_aggr_bench.sv
module gpio_irq_aggr_bench;

    localparam int NB = 5;
    localparam int NG = 10;
    localparam int DP = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         reg_sel = 1'b0;
    logic         reg_we = 1'b0;
    logic [7:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [159:0] bank_rdata = '0;
    logic [159:0] status = '0;

    logic [31:0]  rdata_a, rdata_b;
    logic [4:0]   bsel_a, bsel_b;
    logic [3:0]   bword_a, bword_b;
    logic [9:0]   grp_a, grp_b;
    logic [0:0]   dir_a;
    logic [3:0]   dir_b;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_irq_aggr u_gpio_irq_aggr (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_a),
        .bank_sel(bsel_a), .bank_word(bword_a), .bank_rdata(bank_rdata),
        .bank_status(status), .irq_grp(grp_a), .irq_direct(dir_a)
    );

    gpio_irq_aggr #(.DIRECT_PINS(DP)) u_gpio_irq_aggr_direct (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_b),
        .bank_sel(bsel_b), .bank_word(bword_b), .bank_rdata(bank_rdata),
        .bank_status(status), .irq_grp(grp_b), .irq_direct(dir_b)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural reference, advanced on each rising edge
    logic [9:0] en_m = '0, exp_grp = '0;
    logic       en_d = 1'b0;
    logic [3:0] exp_dir = '0;

    always @(posedge clk) begin
        if (rst) begin
            en_m = '0; en_d = 1'b0; exp_grp = '0; exp_dir = '0;
        end else begin
            for (int g = 0; g < NG; g++) begin
                exp_grp[g] = en_m[g] && (((status >> (16 * g)) & 160'hFFFF) != 0);
            end
            exp_dir = en_d ? status[3:0] : 4'h0;
            if (reg_sel && reg_we && reg_addr == 8'h08) begin
                en_m = reg_wdata[9:0];
                en_d = reg_wdata[0];
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            chk(grp_a == exp_grp, "R5 R6 R7 R9 grouped model", 32'(grp_a), 32'(exp_grp));
            chk(grp_b == '0, "R8 grouped lines quiet", 32'(grp_b), 32'h0);
            chk(dir_b == exp_dir, "R8 R7 direct model", 32'(dir_b), 32'(exp_dir));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_we = 1'b0;
    endtask

    task automatic acc(input logic [7:0] a, input logic [4:0] esel,
                       input logic [3:0] eword, input logic [31:0] ea,
                       input logic [31:0] eb, input string req);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1;
        chk(bsel_a == esel, req, 32'(bsel_a), 32'(esel));
        if (esel != '0) chk(bword_a == eword, req, 32'(bword_a), 32'(eword));
        chk(rdata_a == ea, req, rdata_a, ea);
        chk(rdata_b == eb, req, rdata_b, eb);
        reg_sel = 1'b0;
    endtask

    task automatic set_st(input logic [159:0] v);
        @(negedge clk);
        status = v;
    endtask

    task automatic grp_next(input logic [9:0] e, input string req);
        @(negedge clk);
        chk(grp_a == e, req, 32'(grp_a), 32'(e));
    endtask

    function automatic logic [31:0] pat(input int k);
        return 32'hA500_0000 | (32'(k + 1) * 32'h0001_0101);
    endfunction

    initial begin
        for (int k = 0; k < NB; k++) bank_rdata[32*k +: 32] = pat(k);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state, R4 enable resets to zero
        chk(grp_a == '0, "R9 grouped after reset", 32'(grp_a), 32'h0);
        chk(dir_b == '0, "R9 direct after reset", 32'(dir_b), 32'h0);
        acc(8'h08, 5'h0, 4'h0, 32'h0, 32'h0, "R4 enable reset value");

        // R1 R3 bank group decode, first and last word of each group
        for (int k = 0; k < NB; k++) begin
            acc(8'(16 + 40 * k), 5'(1 << k), 4'd0, pat(k), pat(k), "R1 R3 group start");
            acc(8'(16 + 40 * k + 36), 5'(1 << k), 4'd9, pat(k), pat(k), "R1 R3 group end");
        end

        // R2 unmapped offsets
        acc(8'h00, 5'h0, 4'h0, 32'h0, 32'h0, "R2 offset 0x00");
        acc(8'h04, 5'h0, 4'h0, 32'h0, 32'h0, "R2 offset 0x04");
        acc(8'h0C, 5'h0, 4'h0, 32'h0, 32'h0, "R2 offset 0x0C");
        acc(8'hD8, 5'h0, 4'h0, 32'h0, 32'h0, "R2 past fifth group");
        acc(8'hFC, 5'h0, 4'h0, 32'h0, 32'h0, "R2 top of window");

        // R4 enable write and read back, R8 direct keeps bit 0 only
        wr(8'h08, 32'hFFFF_FFFF);
        acc(8'h08, 5'h0, 4'h0, 32'h3FF, 32'h1, "R4 R8 enable readback");
        wr(8'h0C, 32'h0);
        wr(8'h14, 32'h0);
        acc(8'h08, 5'h0, 4'h0, 32'h3FF, 32'h1, "R2 R4 stray writes ignored");

        // R5 group split
        set_st({32'h0001_0000, 32'h0, 32'h0, 32'h0, 32'h0000_0001});
        grp_next(10'b10_0000_0001, "R5 low half bank0, high half bank4");
        set_st({32'h0, 32'h0, 32'h8000_0000, 32'h0, 32'h0});
        grp_next(10'b00_0010_0000, "R5 high half bank2");

        // R6 level hold, then drop once cleared
        for (int i = 0; i < 4; i++) grp_next(10'b00_0010_0000, "R6 level held");
        set_st('0);
        grp_next(10'h0, "R6 drop after clear");

        // R7 enable change takes effect one cycle after its write edge
        set_st({5{32'hFFFF_FFFF}});
        grp_next(10'h3FF, "R5 all groups pending");
        wr(8'h08, 32'h0000_0201);
        #1 chk(grp_a == 10'h3FF, "R7 old value during write cycle", 32'(grp_a), 32'h3FF);
        grp_next(10'h201, "R4 R7 masked groups");

        // R8 direct lines: pins 1,3,4 pending; pin 4 beyond the direct range
        set_st({128'h0, 32'h0000_001A});
        @(negedge clk);
        chk(dir_b == 4'b1010, "R8 direct per-pin", 32'(dir_b), 32'hA);
        wr(8'h08, 32'hFFFF_FFFE);
        acc(8'h08, 5'h0, 4'h0, 32'h3FE, 32'h0, "R8 upper enable bits dropped");
        chk(dir_b == 4'b0000, "R8 direct gated by enable bit 0", 32'(dir_b), 32'h0);
        wr(8'h08, 32'h0000_0001);
        @(negedge clk);
        chk(dir_b == 4'b1010, "R8 direct re-enabled", 32'(dir_b), 32'hA);

        // Random sparse status with occasional enable writes
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            for (int k = 0; k < NB; k++) begin
                status[32*k +: 32] = $urandom & $urandom & $urandom & $urandom;
            end
            if (i % 16 == 0) begin
                reg_sel = 1'b1; reg_we = 1'b1; reg_addr = 8'h08; reg_wdata = $urandom;
            end else begin
                reg_sel = 1'b0; reg_we = 1'b0;
            end
        end
        @(negedge clk);
        reg_sel = 1'b0; reg_we = 1'b0;
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule